// File: doc/BRIEF.md
# Two-Wire Target Engine with Busy Polling

This block is the serial front end of a register-based peripheral that sits on a two-wire (I2C) bus as a target. It runs on a fast system clock and oversamples the SCL and SDA lines. A synchronizer and a glitch filter clean both lines before edge detection. It recognises START and STOP, takes the first byte after START as an 8-bit address, acknowledges each byte it accepts and shifts read data out most significant bit first. SDA is driven through an output enable, so the pad is open-drain.

The address byte has no direction bit. After the address, a controller behind the engine decides byte by byte whether the next byte is received or sent, and whether a received byte is acknowledged. While that controller reports an internal nonvolatile write in progress, the engine stays silent. A bus master can therefore repeat START plus address until it gets an acknowledge, which tells it the write has finished.

Top module: `i2c_poll_target`

## Requirements
- R1: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A START at any point, including the middle of a byte, restarts address reception, and the data byte index returns to 0.
- R2: The address byte is taken MSB first. Its bits 7..4 must equal 0101 and its bits 3..0 must equal `strap_addr`. On a mismatch the engine leaves SDA released and ignores all traffic until the next START.
- R3: On a match, `sda_oe` is high during the ninth SCL clock and is released after the SCL fall that ends that clock. `addr_hit` pulses for one cycle when the acknowledge begins.
- R4: Each received data byte gives a one-cycle `rx_valid` pulse after its eighth SCL rise. `rx_data` holds the byte, MSB first. `rx_index` is 0 for the first byte after the address, then counts up and saturates at its maximum.
- R5: `ack_en` is sampled at the SCL fall after the eighth bit of a received byte. High gives an acknowledge. Low leaves SDA released, and the engine then ignores the bus until START or STOP.
- R6: `xmit_sel` is sampled at the SCL fall that ends each acknowledge. When it is high, `tx_load` pulses, `tx_data` is captured and sent MSB first, and `sda_oe` is high while the current bit is 0. `sda_oe` changes only while SCL is low.
- R7: After 8 sent bits the engine releases SDA and samples the master on the ninth SCL rise. SDA low (acknowledge) continues with the next byte. SDA high leaves SDA released until START or STOP.
- R8: While `busy` is high, any SCL fall inside a transaction releases SDA and silences the engine until the next START, so the address is not acknowledged. Once `busy` is low, the same address is acknowledged again.
- R9: `stop_seen` pulses for one cycle on each STOP. `rx_valid`, `tx_load`, `addr_hit` and `stop_seen` never pulse in the same cycle.
- R10: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks has no effect on the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| strap_addr | input | STRAP_W | Board strap bits matched against address bits 3..0 |
| busy | input | 1 | Internal write cycle in progress; engine stays silent |
| ack_en | input | 1 | Controller accepts the byte just received |
| xmit_sel | input | 1 | Next byte is sent by the engine |
| tx_data | input | 8 | Byte to send, captured on `tx_load` |
| sda_oe | output | 1 | Pull SDA low when high |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Last received data byte |
| rx_index | output | IDX_W | Position of the received byte after the address |
| tx_load | output | 1 | One-cycle strobe: `tx_data` captured |
| addr_hit | output | 1 | One-cycle strobe: address matched and acknowledged |
| stop_seen | output | 1 | One-cycle strobe: STOP detected |

## Verification
The assertions assume a master that follows the bus rules. SDA changes only while SCL is low, except for START and STOP. No STOP or START is issued while the engine holds SDA low. Every SCL phase is much longer than the synchronizer plus filter latency. The bench drives SCL and SDA with phases of 16 system clocks, against a filter length of 4. It changes the master's SDA only in the low phase, except in the START and STOP tasks. It models the wired-AND bus, so the master reads back the engine's pull-down. Its only glitches are pulses of 2 clocks, shorter than the filter length.

// File: rtl/i2c_poll_target_pkg.sv
package i2c_poll_target_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      TS_IDLE,
      TS_ADDR,
      TS_ADDR_ACK,
      TS_RX,
      TS_RX_ACK,
      TS_TX,
      TS_TX_ACK,
      TS_MUTE
   } tgt_state_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_clean
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 0) begin : g_bad_filt
      $error("FILT_LEN must not be negative");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], line_raw};
   end
   assign synced = chain[SYNC_STAGES-1];

   if (FILT_LEN == 0) begin : g_nofilt
      assign line_clean = synced;
   end else begin : g_filt
      localparam int CW = $clog2(FILT_LEN + 1);
      localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
      logic [CW-1:0] run;
      logic          held;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run  <= '0;
            held <= 1'b1;
         end else if (synced == held) begin
            run <= '0;
         end else if (run == LAST) begin
            held <= synced;
            run  <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end
      assign line_clean = held;

      AST_FILT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(held) |-> held == $past(synced)) else $error("filter output flipped against input"); // R10
   end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_c,
   input  logic sda_c,
   output logic start_ev,
   output logic stop_ev,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_c;
         sda_p <= sda_c;
      end
   end

   assign start_ev = scl_p & scl_c & sda_p & ~sda_c;
   assign stop_ev  = scl_p & scl_c & ~sda_p & sda_c;
   assign scl_rise = ~scl_p & scl_c;
   assign scl_fall = scl_p & ~scl_c;

   AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_ev, stop_ev, scl_rise, scl_fall})) else $error("bus events overlap"); // R1
endmodule

// File: rtl/i2c_poll_target.sv
module i2c_poll_target
   import i2c_poll_target_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 4,
   parameter int         IDX_W       = 3,
   parameter int         ID_W        = 4,
   parameter int         STRAP_W     = 4,
   parameter logic [3:0] ID_NIBBLE   = 4'b0101
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   input  logic [STRAP_W-1:0] strap_addr,
   input  logic               busy,
   input  logic               ack_en,
   input  logic               xmit_sel,
   input  logic [BYTE_W-1:0]  tx_data,
   output logic               sda_oe,
   output logic               rx_valid,
   output logic [BYTE_W-1:0]  rx_data,
   output logic [IDX_W-1:0]   rx_index,
   output logic               tx_load,
   output logic               addr_hit,
   output logic               stop_seen
);
   localparam int ADDR_W = ID_W + STRAP_W;
   localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
   localparam logic [3:0] LAST_BIT = 4'd8;

   if (ADDR_W != BYTE_W) begin : g_bad_addr
      $error("ID_W + STRAP_W must equal one byte");
   end
   if (ID_W != 4) begin : g_bad_id
      $error("ID_W must be 4 to hold ID_NIBBLE");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must be at least 1");
   end

   logic [1:0] raw_lines, clean_lines;
   assign raw_lines = {scl_in, sda_in};

   for (genvar g = 0; g < 2; g++) begin : g_line
      i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
         .clk        (clk),
         .rst_n      (rst_n),
         .line_raw   (raw_lines[g]),
         .line_clean (clean_lines[g])
      );
   end

   logic scl_f, sda_f;
   assign scl_f = clean_lines[1];
   assign sda_f = clean_lines[0];

   logic start_ev, stop_ev, scl_rise, scl_fall;
   i2c_bus_events u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_c    (scl_f),
      .sda_c    (sda_f),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall)
   );

   tgt_state_e        state;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic [IDX_W-1:0]  idx;
   logic              m_ack, oe_q;
   logic              advance;
   logic [ADDR_W-1:0] my_addr;

   assign my_addr = {ID_NIBBLE, strap_addr};
   assign advance = scl_fall && !busy &&
                    (state == TS_ADDR_ACK || state == TS_RX_ACK ||
                     (state == TS_TX_ACK && m_ack));
   assign sda_oe  = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= TS_IDLE;
         bitcnt    <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         idx       <= '0;
         m_ack     <= 1'b0;
         oe_q      <= 1'b0;
         rx_valid  <= 1'b0;
         rx_data   <= '0;
         rx_index  <= '0;
         tx_load   <= 1'b0;
         addr_hit  <= 1'b0;
         stop_seen <= 1'b0;
      end else begin
         rx_valid  <= 1'b0;
         tx_load   <= 1'b0;
         addr_hit  <= 1'b0;
         stop_seen <= 1'b0;
         if (stop_ev) begin
            state     <= TS_IDLE;
            oe_q      <= 1'b0;
            stop_seen <= 1'b1;
         end else if (start_ev) begin
            state  <= TS_ADDR;
            bitcnt <= '0;
            oe_q   <= 1'b0;
            idx    <= '0;
         end else if (scl_rise) begin
            case (state)
               TS_ADDR, TS_RX: begin
                  rx_sh  <= {rx_sh[BYTE_W-2:0], sda_f};
                  bitcnt <= bitcnt + 1'b1;
                  if (state == TS_RX && bitcnt == LAST_BIT - 1'b1) begin
                     rx_valid <= 1'b1;
                     rx_data  <= {rx_sh[BYTE_W-2:0], sda_f};
                     rx_index <= idx;
                  end
               end
               TS_TX:     bitcnt <= bitcnt + 1'b1;
               TS_TX_ACK: m_ack  <= ~sda_f;
               default: ;
            endcase
         end else if (scl_fall) begin
            if (busy && state != TS_IDLE) begin
               state <= TS_MUTE;
               oe_q  <= 1'b0;
            end else if (advance) begin
               bitcnt <= '0;
               if (state == TS_RX_ACK && idx != IDX_MAX) idx <= idx + 1'b1;
               if (xmit_sel) begin
                  state   <= TS_TX;
                  tx_load <= 1'b1;
                  tx_sh   <= tx_data;
                  oe_q    <= ~tx_data[BYTE_W-1];
               end else begin
                  state <= TS_RX;
                  oe_q  <= 1'b0;
               end
            end else begin
               case (state)
                  TS_ADDR: if (bitcnt == LAST_BIT) begin
                     if (rx_sh == my_addr) begin
                        oe_q     <= 1'b1;
                        state    <= TS_ADDR_ACK;
                        addr_hit <= 1'b1;
                     end else begin
                        state <= TS_MUTE;
                     end
                  end
                  TS_RX: if (bitcnt == LAST_BIT) begin
                     if (ack_en) begin
                        oe_q  <= 1'b1;
                        state <= TS_RX_ACK;
                     end else begin
                        state <= TS_MUTE;
                     end
                  end
                  TS_TX: if (bitcnt == LAST_BIT) begin
                     oe_q  <= 1'b0;
                     state <= TS_TX_ACK;
                  end else begin
                     oe_q  <= ~tx_sh[BYTE_W-2];
                     tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                  end
                  TS_TX_ACK: state <= TS_MUTE;
                  default: ;
               endcase
            end
         end
      end
   end

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> !scl_f) else $error("SDA drive changed with SCL high"); // R6
   AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_fall && busy) |=> !sda_oe) else $error("drive while busy"); // R8
   AST_HIT_DRIVES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hit |-> sda_oe && !$past(busy)) else $error("address hit without acknowledge"); // R3
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_valid, tx_load, addr_hit, stop_seen})) else $error("strobes overlap"); // R9
   AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= LAST_BIT) else $error("bit counter overflow"); // R4
   AST_RX_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> $stable(rx_data)) else $error("received byte changed right after strobe"); // R4
endmodule

// File: tb/i2c_poll_target_bench.sv
module i2c_poll_target_bench;
   localparam int Q = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic [3:0] strap = 4'hA;
   logic       busy = 1'b0, ack_en = 1'b1, xmit_sel = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       sda_oe, rx_valid, tx_load, addr_hit, stop_seen;
   logic [7:0] rx_data;
   logic [2:0] rx_index;
   logic       sda_bus;
   assign sda_bus = sda_m & ~sda_oe;

   i2c_poll_target u_i2c_poll_target (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
      .strap_addr(strap), .busy(busy), .ack_en(ack_en), .xmit_sel(xmit_sel),
      .tx_data(tx_data), .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_index(rx_index), .tx_load(tx_load), .addr_hit(addr_hit), .stop_seen(stop_seen)
   );

   int total = 0, bad = 0;
   int rx_cnt = 0, tx_cnt = 0, hit_cnt = 0, stop_cnt = 0;
   logic [7:0] last_rx = 8'h00;
   logic [2:0] last_idx = 3'd0;
   bit done = 1'b0;

   always @(posedge clk) begin
      if (rx_valid) begin
         rx_cnt <= rx_cnt + 1;
         last_rx <= rx_data;
         last_idx <= rx_index;
      end
      if (tx_load) tx_cnt <= tx_cnt + 1;
      if (addr_hit) hit_cnt <= hit_cnt + 1;
      if (stop_seen) stop_cnt <= stop_cnt + 1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q / 2); b = sda_bus; wq(Q / 2); scl_m = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(a);
      acked = ~a;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(~give_ack);
   endtask

   // bit with a short SCL pulse in its low phase and a short SDA dip in its high phase
   task automatic put_bit_glitch(input logic b);
      sda_m = b; wq(Q / 2);
      scl_m = 1'b1; wq(2); scl_m = 1'b0;
      wq(Q / 2);
      scl_m = 1'b1; wq(Q / 2);
      sda_m = ~b; wq(2); sda_m = b;
      wq(Q / 2 - 2); scl_m = 1'b0; wq(Q);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic ak;
      logic [7:0] d;
      int r0, h0;
      wq(5);
      // R9 reset state
      chk(!sda_oe && !rx_valid && !tx_load && !addr_hit && !stop_seen, "R9 reset outputs", sda_oe, 0);
      rst_n = 1'b1;
      wq(10);

      // R2 R3 R4 R5: matching address and two acknowledged writes
      bus_start();
      send_byte(8'h5A, ak);
      chk(ak, "R3 address ack", ak, 1);
      chk(!sda_oe, "R3 ack released after ninth clock", sda_oe, 0);
      chk(hit_cnt == 1, "R3 addr_hit count", hit_cnt, 1);
      send_byte(8'h96, ak);
      chk(ak, "R5 data ack with ack_en", ak, 1);
      chk(last_rx == 8'h96 && last_idx == 0, "R4 first byte and index", {last_idx, last_rx}, 12'h096);
      send_byte(8'h3C, ak);
      chk(last_rx == 8'h3C && last_idx == 1, "R4 second byte and index", {last_idx, last_rx}, 12'h13C);
      chk(rx_cnt == 2, "R4 rx strobe count", rx_cnt, 2);
      bus_stop();
      wq(Q);
      chk(stop_cnt == 1, "R9 stop strobe", stop_cnt, 1);

      // R4 index saturation over a long write
      bus_start();
      send_byte(8'h5A, ak);
      for (int k = 0; k < 10; k++) begin
         send_byte(8'(k * 17 + 3), ak);
         chk(ak && last_rx == 8'(k * 17 + 3) && last_idx == 3'((k > 7) ? 7 : k),
             "R4 index saturates", {last_idx, last_rx}, {(k > 7) ? 7 : k, 8'(k * 17 + 3)});
      end
      bus_stop();

      // R2 sweep: all low nibbles and all high nibbles
      for (int s = 0; s < 32; s++) begin
         logic [7:0] a;
         logic exp_ack;
         a = (s < 16) ? {4'b0101, 4'(s)} : {4'(s - 16), 4'hA};
         exp_ack = (a == 8'h5A);
         r0 = rx_cnt;
         bus_start();
         send_byte(a, ak);
         chk(ak == exp_ack, "R2 address match", ak, exp_ack);
         send_byte(8'h77, ak);
         chk(ak == exp_ack && (rx_cnt - r0) == int'(exp_ack), "R2 traffic after address",
             rx_cnt - r0, int'(exp_ack));
         bus_stop();
      end

      // R5 refused byte silences the rest
      bus_start();
      send_byte(8'h5A, ak);
      ack_en = 1'b0;
      send_byte(8'h12, ak);
      chk(!ak, "R5 refused byte not acked", ak, 0);
      ack_en = 1'b1;
      r0 = rx_cnt;
      send_byte(8'h34, ak);
      chk(!ak && rx_cnt == r0, "R5 ignored after refusal", rx_cnt - r0, 0);
      bus_stop();

      // R6 R7 transmit with master ack then nack
      bus_start();
      send_byte(8'h5A, ak);
      xmit_sel = 1'b1;
      tx_data = 8'hC5;
      send_byte(8'h90, ak);
      tx_data = 8'h3A;
      chk(tx_cnt == 1, "R6 tx_load after instruction", tx_cnt, 1);
      recv_byte(d, 1'b1);
      chk(d == 8'hC5, "R6 first sent byte", d, 8'hC5);
      recv_byte(d, 1'b0);
      chk(d == 8'h3A, "R7 second byte after master ack", d, 8'h3A);
      recv_byte(d, 1'b0);
      chk(d == 8'hFF && tx_cnt == 2, "R7 silent after master nack", d, 8'hFF);
      xmit_sel = 1'b0;
      bus_stop();

      // R1 repeated start in the middle of a byte
      bus_start();
      send_byte(8'h5A, ak);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      r0 = rx_cnt;
      bus_start();
      send_byte(8'h5A, ak);
      chk(ak, "R1 restart accepts address", ak, 1);
      send_byte(8'h11, ak);
      chk(rx_cnt == r0 + 1 && last_rx == 8'h11 && last_idx == 0, "R1 index reset by restart",
          {last_idx, last_rx}, 12'h011);
      bus_stop();

      // R8 busy polling
      busy = 1'b1;
      h0 = hit_cnt;
      bus_start();
      send_byte(8'h5A, ak);
      chk(!ak && hit_cnt == h0, "R8 no ack while busy", ak, 0);
      send_byte(8'h22, ak);
      chk(!ak, "R8 silent while busy", ak, 0);
      bus_stop();
      busy = 1'b0;
      bus_start();
      send_byte(8'h5A, ak);
      chk(ak, "R8 ack after busy clears", ak, 1);
      busy = 1'b1;
      r0 = rx_cnt;
      send_byte(8'h44, ak);
      chk(!ak && rx_cnt == r0, "R8 busy mid transaction", rx_cnt - r0, 0);
      busy = 1'b0;
      bus_stop();

      // R10 short glitches on both lines
      bus_start();
      send_byte(8'h5A, ak);
      r0 = rx_cnt;
      for (int i = 7; i >= 0; i--) put_bit_glitch(((8'hA5 >> i) & 8'h01) != 0);
      get_bit(ak);
      chk(!ak && rx_cnt == r0 + 1 && last_rx == 8'hA5, "R10 glitches ignored", last_rx, 8'hA5);
      bus_stop();
      wq(Q);
      chk(!sda_oe, "R10 idle after glitch test", sda_oe, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule